// File: doc/BRIEF.md
# Nine-Bit Asynchronous Frame Transmitter

This block serialises one asynchronous frame at a time onto a single output line. A frame is eleven bit times long. It contains a low start bit, eight payload bits sent least significant first, a ninth bit chosen by the writer, and a high stop bit. The payload byte and the ninth bit arrive together on a valid/ready write port. Bit timing comes from a free-running rollover pulse supplied from outside, one pulse per bit time. The frame starts on the first rollover after the write, so the bit edges line up with the rollover pulse rather than with the write.

The block does not count bits. It loads a nine-bit shift register with the payload and the ninth bit. The first shift pushes a single marker 1 in from the top, and every later shift fills the top with 0. When the ninth bit reaches the output, the marker sits directly above it and everything higher is zero. That pattern triggers one last shift, which puts the marker (the stop level) on the line. On that same rollover the block returns to idle and raises a sticky completion flag. Software clears the flag with a one-cycle strobe.

Back-pressure on the write port: `wr_ready` is high only while the block is idle. A transfer happens on a rising clock edge where `wr_valid` and `wr_ready` are both high. While a frame is pending or in flight, `wr_ready` is low, so a valid write is neither taken nor stored, and the writer must hold it until ready returns.

Top module: `ninebit_tx`

## Requirements
- R1: After reset and whenever idle, `txd` is 1, `wr_ready` is 1 and `done_flag` is 0 until a frame completes.
- R2: An accepted write (valid and ready high at a clock edge) makes `wr_ready` 0 from the next cycle until the frame completes.
- R3: `txd` stays 1 after an accepted write until the first `bit_tick` after the accepting edge; from that tick's edge the start bit (0) is driven for one bit time.
- R4: On each of the next eight `bit_tick` edges `txd` takes the next payload bit, bit 0 first and bit 7 last.
- R5: On the tenth `bit_tick` after the write, `txd` takes the ninth bit given with the write.
- R6: On the eleventh `bit_tick` after the write, `txd` goes to 1 (stop level), `done_flag` is set and `wr_ready` returns to 1, all at the same edge.
- R7: While `wr_ready` is 0, a valid write has no effect: the frame in flight keeps its original bits and no second frame follows it.
- R8: `done_flag` holds its value until a cycle with `done_clr` high clears it at the next edge. If a frame completes in the same cycle as `done_clr`, the flag is set.
- R9: Synchronous reset (`rst` high at an edge) returns the block to idle: `txd` 1, `done_flag` 0, `wr_ready` 1, and no frame starts on later ticks.
- R10: A `bit_tick` in the same cycle as the accepting edge does not start the frame; the start bit waits for the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse at each divide-by-16 rollover (one per bit time) |
| wr_valid | input | 1 | Write request carrying a frame |
| wr_ready | output | 1 | High while idle; a write is taken when valid and ready are both high |
| wr_data | input | DATA_W | Payload byte, sent least significant bit first |
| wr_bit9 | input | 1 | Ninth bit, sent after the payload |
| done_clr | input | 1 | One-cycle strobe that clears `done_flag` |
| done_flag | output | 1 | Sticky frame-complete flag |
| txd | output | 1 | Serial line output, high when idle |

## Verification
Every result is due a fixed number of ticks after the accepting edge and is visible in the cycle after that tick's edge: the start bit after the first tick, payload bit k after tick k+2, the ninth bit after the tenth tick, and the stop level, set flag and raised ready after the eleventh. `done_clr` takes effect one cycle after the strobe. The bench drives inputs and samples outputs on falling edges. It steps through the frame by waiting for a falling edge where `bit_tick` is high, then samples on the following falling edge, after the rising edge that consumes the tick. Writes are placed both away from ticks and exactly on a tick cycle, so the rule that a same-cycle tick is not counted is checked directly.

// File: rtl/ninebit_tx_pkg.sv
package ninebit_tx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PEND  = 3'd1,
    PH_START = 3'd2,
    PH_FIRST = 3'd3,
    PH_SHIFT = 3'd4
  } tx_phase_t;
endpackage

// File: rtl/ninebit_tx_shreg.sv
module ninebit_tx_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_bit9,
  input  logic              shift,
  input  logic              fill_one,
  output logic              out_bit,
  output logic              at_end
);
  localparam int SR_W = DATA_W + 1;

  logic [SR_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (load) begin
      sr <= {load_bit9, load_data};
    end else if (shift) begin
      sr <= {fill_one, sr[SR_W-1:1]};
    end
  end

  assign out_bit = sr[0];
  // marker just above the output position, nothing set above it
  assign at_end  = (sr[SR_W-1:2] == '0) && sr[1];

  AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift) |=> (sr == $past(sr)));                  // R7

  AST_SR_MARKER_LOADED: assert property (@(posedge clk) disable iff (rst)
    (shift && !load && fill_one) |=> sr[SR_W-1]);             // R6
endmodule

// File: rtl/ninebit_tx_ctrl.sv
module ninebit_tx_ctrl
  import ninebit_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      accept,
  input  logic      bit_tick,
  input  logic      at_end,
  input  logic      done_clr,
  output tx_phase_t phase,
  output logic      do_shift,
  output logic      fill_one,
  output logic      done_flag
);
  tx_phase_t phase_nx;
  logic      finish;

  always_comb begin
    phase_nx = phase;
    do_shift = 1'b0;
    fill_one = 1'b0;
    finish   = 1'b0;
    unique case (phase)
      PH_IDLE:  if (accept) phase_nx = PH_PEND;
      PH_PEND:  if (bit_tick) phase_nx = PH_START;
      PH_START: if (bit_tick) phase_nx = PH_FIRST;
      PH_FIRST: if (bit_tick) begin
        phase_nx = PH_SHIFT;
        do_shift = 1'b1;
        fill_one = 1'b1;
      end
      PH_SHIFT: if (bit_tick) begin
        do_shift = 1'b1;
        if (at_end) begin
          phase_nx = PH_IDLE;
          finish   = 1'b1;
        end
      end
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      done_flag <= 1'b0;
    end else begin
      phase <= phase_nx;
      if (finish)        done_flag <= 1'b1;
      else if (done_clr) done_flag <= 1'b0;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !done_clr) |=> done_flag);                   // R8

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (done_clr && !(bit_tick && phase == PH_SHIFT && at_end)) |=> !done_flag); // R8

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && !bit_tick) |=> (phase == $past(phase))); // R3

  AST_FLAG_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> (phase == PH_IDLE));                  // R6

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (phase == PH_IDLE && !done_flag));          // R9
endmodule

// File: rtl/ninebit_tx.sv
module ninebit_tx
  import ninebit_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              done_clr,
  output logic              done_flag,
  output logic              txd
);
  tx_phase_t phase;
  logic      accept;
  logic      do_shift;
  logic      fill_one;
  logic      out_bit;
  logic      at_end;

  assign wr_ready = (phase == PH_IDLE);
  assign accept   = wr_valid && wr_ready;

  ninebit_tx_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .bit_tick  (bit_tick),
    .at_end    (at_end),
    .done_clr  (done_clr),
    .phase     (phase),
    .do_shift  (do_shift),
    .fill_one  (fill_one),
    .done_flag (done_flag)
  );

  ninebit_tx_shreg #(.DATA_W(DATA_W)) u_sr (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_data (wr_data),
    .load_bit9 (wr_bit9),
    .shift     (do_shift),
    .fill_one  (fill_one),
    .out_bit   (out_bit),
    .at_end    (at_end)
  );

  always_comb begin
    unique case (phase)
      PH_START:          txd = 1'b0;
      PH_FIRST, PH_SHIFT: txd = out_bit;
      default:           txd = 1'b1;
    endcase
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    accept |=> !wr_ready);                                     // R2

  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(txd) && $past(phase == PH_PEND) |-> $past(bit_tick)); // R3
endmodule

// File: tb/sim_ninebit_tx.sv
module sim_ninebit_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       wr_bit9 = 1'b0;
  logic       done_clr = 1'b0;
  logic       done_flag;
  logic       txd;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int tcnt = 0;

  always #4 clk = ~clk;

  always @(posedge clk) tcnt <= (tcnt == 4) ? 0 : tcnt + 1;
  assign bit_tick = (tcnt == 4);

  ninebit_tx #(.DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_bit9(wr_bit9),
    .done_clr(done_clr), .done_flag(done_flag), .txd(txd)
  );

  // {ninth bit, payload}
  localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h155, 9'h000, 9'h1FF, 9'h102, 9'h081};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // at a negedge: wait for a tick-high cycle, then sample after its edge
  task automatic to_tick();
    while (!bit_tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, logic b9);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_bit9 = b9;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic clear_flag();
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk("R8 cleared", done_flag, 0);
  endtask

  task automatic run_frame(logic [7:0] d, logic b9);
    send(d, b9);
    chk("R3 line high before tick", txd, 1);
    chk("R2 ready low", wr_ready, 0);
    for (int k = 1; k <= 11; k++) begin
      to_tick();
      if (k == 1)       chk("R3 start bit", txd, 0);
      else if (k <= 9)  chk("R4 data bit", txd, d[k-2]);
      else if (k == 10) chk("R5 ninth bit", txd, b9);
      else begin
        chk("R6 stop level", txd, 1);
        chk("R6 flag set", done_flag, 1);
        chk("R6 ready back", wr_ready, 1);
      end
      if (k == 10) chk("R6 flag not early", done_flag, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle line", txd, 1);
    chk("R1 idle ready", wr_ready, 1);
    chk("R1 idle flag", done_flag, 0);

    // vector table
    for (int i = 0; i < 6; i++) begin
      run_frame(VEC[i][7:0], VEC[i][8]);
      clear_flag();
    end

    // R8: flag sticky over several ticks
    run_frame(8'h3C, 1'b0);
    to_tick(); to_tick();
    chk("R8 flag held", done_flag, 1);
    chk("R1 idle after frame", txd, 1);
    clear_flag();

    // R10: write lands on a tick cycle
    while (!bit_tick) @(negedge clk);
    send(8'hC3, 1'b1);
    chk("R10 no start on same tick", txd, 1);
    for (int k = 1; k <= 11; k++) begin
      to_tick();
      if (k == 1)       chk("R10 start on next tick", txd, 0);
      else if (k <= 9)  chk("R4 data bit", txd, 8'hC3 >> (k-2) & 1);
      else if (k == 10) chk("R5 ninth bit", txd, 1);
      else              chk("R6 flag set", done_flag, 1);
    end
    clear_flag();

    // R7: write during a frame is ignored
    send(8'h0F, 1'b0);
    to_tick(); to_tick(); to_tick();
    wr_valid = 1'b1; wr_data = 8'hF0; wr_bit9 = 1'b1;
    chk("R7 ready low while busy", wr_ready, 0);
    @(negedge clk);
    wr_valid = 1'b0;
    for (int k = 4; k <= 11; k++) begin
      to_tick();
      if (k <= 9)       chk("R7 original data kept", txd, 8'h0F >> (k-2) & 1);
      else if (k == 10) chk("R7 original ninth kept", txd, 0);
      else              chk("R6 flag set", done_flag, 1);
    end
    for (int k = 0; k < 3; k++) begin
      to_tick();
      chk("R7 no second frame", txd, 1);
    end
    clear_flag();

    // R8: completion coinciding with clear sets the flag
    send(8'h81, 1'b0);
    for (int k = 1; k <= 10; k++) to_tick();
    while (!bit_tick) @(negedge clk);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk("R8 set wins over clear", done_flag, 1);
    clear_flag();

    // R9: reset mid-frame
    send(8'h00, 1'b0);
    to_tick(); to_tick();
    chk("R9 frame running", txd, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 line high", txd, 1);
    chk("R9 ready high", wr_ready, 1);
    chk("R9 flag low", done_flag, 0);
    for (int k = 0; k < 3; k++) begin
      to_tick();
      chk("R9 no frame after reset", txd, 1);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule